// File: doc/BRIEF.md
# Bus Target Transaction Sequencer

This block is the control sequencer of a 33 MHz parallel-bus target. It watches the initiator's active-low framing signal (`frameN`), its ready signal (`irdyN`) and the command/byte-enable lines (`cbeN`). It also watches a hit flag from a separate address comparator. From these it drives the registered active-low target-ready, device-select and stop signals, together with one output enable that stands in for the bus tri-state drivers.

The sequencer has four states: idle, address compare, data transfer and back-off. While idle, it predecodes the command lines on every clock, so the command flags are ready when the address phase is seen. Write bursts move one data word per clock once the target is selected. Read bursts insert one wait state before each word. A target-disconnect request input makes the sequencer signal stop. The back-off state then holds device-select and stop until the initiator ends the transaction.

Top module: `tgt_bus_sequencer`

## Requirements
- R1: While reset is held and on the first clock after it, `trdyN`, `devselN` and `stopN` are 1 and `ctrlOe` is 0.
- R2: On the clock edge where `frameN` is first sampled low in idle, `cbeN` is captured. The codes 4'b0110, 4'b1100 and 4'b1110 set `cmdRead`. The codes 4'b0111 and 4'b1111 set `cmdWrite`. All other codes clear both flags. The flags then hold until the sequencer is idle again.
- R3: The edge after the capture edge samples `addrHit`. If `addrHit` is 1 and one command flag is set, then `devselN` goes 0 and `ctrlOe` goes 1 at that edge. Otherwise `devselN` stays 1, `ctrlOe` stays 0, and the sequencer goes back to idle.
- R4: For a write, `trdyN` goes 0 together with `devselN`. It stays 0 for the whole burst, so each data phase lasts one clock plus the number of clocks the initiator holds `irdyN` high.
- R5: For a read, `trdyN` is 1 on the edge where `devselN` goes 0 and goes 0 on the next edge. After every word transferred (`trdyN` and `irdyN` both 0 at an edge), it is 1 for one clock. A read data phase therefore lasts max(2, initiator waits + 1) clocks.
- R6: Once `trdyN` is 0, it stays 0 while `irdyN` is 1.
- R7: A transfer with `frameN` at 1 ends the burst. At that edge `trdyN`, `devselN` and `stopN` become 1 while `ctrlOe` stays 1. `ctrlOe` goes to 0 one edge later.
- R8: If `discReq` is sampled at 1 during the data state, `stopN` goes 0 and `trdyN` goes 1 at that edge. `stopN` then stays 0 until the transaction ends.
- R9: An edge with `stopN` and `irdyN` both 0 enters back-off. There `devselN` and `stopN` stay 0 and `trdyN` stays 1 until an edge sees `irdyN` at 0 and `frameN` at 1. At that edge all three outputs go to 1, and `ctrlOe` goes to 0 one edge later.
- R10: `trdyN` and `stopN` are never both 0 in the same clock.
- R11: In idle with `frameN` at 1, changes on `irdyN`, `cbeN` and `addrHit` leave all outputs at their idle values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameN | input | 1 | Initiator framing signal, active low |
| irdyN | input | 1 | Initiator ready, active low |
| cbeN | input | 4 | Command during the address phase, byte enables afterwards |
| addrHit | input | 1 | Address comparator hit, valid in the clock after the address phase |
| discReq | input | 1 | Request to disconnect the current transaction |
| trdyN | output | 1 | Registered target ready, active low |
| devselN | output | 1 | Registered device select, active low |
| stopN | output | 1 | Registered stop, active low |
| ctrlOe | output | 1 | Output enable for the three target control signals |
| cmdRead | output | 1 | Predecoded read command flag |
| cmdWrite | output | 1 | Predecoded write command flag |

## Verification
The sweep covers every one of the sixteen command codes, both with and without an address hit. This separates the claimed transactions from the ignored ones and checks both command flags for each code. Claimed reads and writes then run bursts of one to three words, with zero to two initiator wait clocks per word. The number of clocks per burst is compared with the arithmetic phase length, which shows whether the one-cycle write rhythm, the two-cycle read rhythm and wait-state holding are each correct. Disconnects are run on a read and on a write. These separate stop holding in the data state, entry into back-off and the release sequence, and the idle stretches between transactions confirm that inputs are ignored there.

// File: rtl/tgt_seq_pkg.sv
package tgt_seq_pkg;

  localparam int CMD_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_CMP_ADDR = 2'd1,
    ST_DTRANS   = 2'd2,
    ST_BACKOFF  = 2'd3
  } seqState_t;

  // Strobes from control to the output datapath, all for the current clock.
  typedef struct packed {
    logic captureCmd;   // sequencer idle: sample the command lines
    logic enterXfer;    // compare -> data transfer this edge
    logic curXfer;      // currently in data transfer
    logic nextXfer;     // data transfer after this edge
    logic nextBackoff;  // back-off after this edge
    logic curActive;    // currently in data transfer or back-off
    logic nextActive;   // data transfer or back-off after this edge
  } seqStrobe_t;

  function automatic logic isReadCmd(input logic [CMD_W-1:0] code);
    return (code == 4'b0110) || (code == 4'b1100) || (code == 4'b1110);
  endfunction

  function automatic logic isWriteCmd(input logic [CMD_W-1:0] code);
    return (code == 4'b0111) || (code == 4'b1111);
  endfunction

endpackage

// File: rtl/tgt_seq_ctrl.sv
module tgt_seq_ctrl
  import tgt_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic       irdyN,
  input  logic       addrHit,
  input  logic       cmdValid,
  input  logic       trdyN,
  input  logic       stopN,
  output seqStrobe_t strobe
);

  seqState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:     if (!frameN) stateD = ST_CMP_ADDR;
      ST_CMP_ADDR: stateD = (addrHit && cmdValid) ? ST_DTRANS : ST_IDLE;
      ST_DTRANS: begin
        if (!trdyN && !irdyN && frameN) stateD = ST_IDLE;
        else if (!stopN && !irdyN)      stateD = ST_BACKOFF;
      end
      ST_BACKOFF:  if (!irdyN && frameN) stateD = ST_IDLE;
      default:     stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.captureCmd  = (stateQ == ST_IDLE);
    strobe.enterXfer   = (stateQ == ST_CMP_ADDR) && (stateD == ST_DTRANS);
    strobe.curXfer     = (stateQ == ST_DTRANS);
    strobe.nextXfer    = (stateD == ST_DTRANS);
    strobe.nextBackoff = (stateD == ST_BACKOFF);
    strobe.curActive   = (stateQ == ST_DTRANS) || (stateQ == ST_BACKOFF);
    strobe.nextActive  = (stateD == ST_DTRANS) || (stateD == ST_BACKOFF);
  end

endmodule

// File: rtl/tgt_seq_datapath.sv
module tgt_seq_datapath
  import tgt_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CMD_W-1:0] cbeN,
  input  logic             irdyN,
  input  logic             discReq,
  input  seqStrobe_t       strobe,
  output logic             trdyN,
  output logic             devselN,
  output logic             stopN,
  output logic             ctrlOe,
  output logic             cmdRead,
  output logic             cmdWrite,
  output logic             cmdValid
);

  logic stopLowD, trdyLowD, devselLowD, oeD;

  // Command predecode, refreshed on every idle clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdRead  <= 1'b0;
      cmdWrite <= 1'b0;
    end else if (strobe.captureCmd) begin
      cmdRead  <= isReadCmd(cbeN);
      cmdWrite <= isWriteCmd(cbeN);
    end
  end

  assign cmdValid = cmdRead || cmdWrite;

  always_comb begin
    stopLowD   = strobe.nextActive &&
                 (strobe.nextBackoff ||
                  (strobe.curXfer && strobe.nextXfer && (discReq || !stopN)));
    trdyLowD   = strobe.nextXfer && !stopLowD &&
                 (strobe.enterXfer ? cmdWrite : (cmdWrite || trdyN || irdyN));
    devselLowD = strobe.nextActive;
    oeD        = strobe.nextActive || strobe.curActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trdyN   <= 1'b1;
      devselN <= 1'b1;
      stopN   <= 1'b1;
      ctrlOe  <= 1'b0;
    end else begin
      trdyN   <= !trdyLowD;
      devselN <= !devselLowD;
      stopN   <= !stopLowD;
      ctrlOe  <= oeD;
    end
  end

endmodule

// File: rtl/tgt_bus_sequencer.sv
module tgt_bus_sequencer
  import tgt_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic             irdyN,
  input  logic [CMD_W-1:0] cbeN,
  input  logic             addrHit,
  input  logic             discReq,
  output logic             trdyN,
  output logic             devselN,
  output logic             stopN,
  output logic             ctrlOe,
  output logic             cmdRead,
  output logic             cmdWrite
);

  seqStrobe_t strobe;
  logic       cmdValid;

  tgt_seq_ctrl ctrlInst (
    .clk      (clk),
    .rstN     (rstN),
    .frameN   (frameN),
    .irdyN    (irdyN),
    .addrHit  (addrHit),
    .cmdValid (cmdValid),
    .trdyN    (trdyN),
    .stopN    (stopN),
    .strobe   (strobe)
  );

  tgt_seq_datapath dpInst (
    .clk      (clk),
    .rstN     (rstN),
    .cbeN     (cbeN),
    .irdyN    (irdyN),
    .discReq  (discReq),
    .strobe   (strobe),
    .trdyN    (trdyN),
    .devselN  (devselN),
    .stopN    (stopN),
    .ctrlOe   (ctrlOe),
    .cmdRead  (cmdRead),
    .cmdWrite (cmdWrite),
    .cmdValid (cmdValid)
  );

endmodule

// File: rtl/tgt_bus_sequencer_chk.sv
module tgt_bus_sequencer_chk (
  input logic clk,
  input logic rstN,
  input logic frameN,
  input logic trdyN,
  input logic devselN,
  input logic stopN,
  input logic ctrlOe
);

  // R10: ready and stop never asserted together
  assert_no_trdy_with_stop_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(!trdyN && !stopN));

  // R7: with the enable released, all three outputs sit high
  assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlOe |-> (trdyN && devselN && stopN));

  // R3: the enable is raised together with device select
  assert_oe_with_devsel_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlOe) |-> !devselN);

  // R7: one high-driven clock precedes release of the enable
  assert_release_after_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlOe) |-> ($past(devselN) && $past(ctrlOe)));

  // R9: device select is dropped only when the framing signal is high
  assert_end_on_frame_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(devselN) |-> $past(frameN));

  // R8: stop holds until the transaction ends
  assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !stopN |=> (!stopN || devselN));

endmodule

bind tgt_bus_sequencer tgt_bus_sequencer_chk chkInst (
  .clk     (clk),
  .rstN    (rstN),
  .frameN  (frameN),
  .trdyN   (trdyN),
  .devselN (devselN),
  .stopN   (stopN),
  .ctrlOe  (ctrlOe)
);

// File: tb/tgt_bus_sequencer_test.sv
module tgt_bus_sequencer_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       frameN, irdyN, addrHit, discReq;
  logic [3:0] cbeN;
  logic       trdyN, devselN, stopN, ctrlOe, cmdRead, cmdWrite;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tgt_bus_sequencer uut (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .cbeN(cbeN),
    .addrHit(addrHit), .discReq(discReq), .trdyN(trdyN), .devselN(devselN),
    .stopN(stopN), .ctrlOe(ctrlOe), .cmdRead(cmdRead), .cmdWrite(cmdWrite)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkIdle(input string req);
    check({req, " trdyN"}, trdyN, 1);
    check({req, " devselN"}, devselN, 1);
    check({req, " stopN"}, stopN, 1);
    check({req, " ctrlOe"}, ctrlOe, 0);
  endtask

  // Address phase plus compare clock; returns with the claim visible.
  task automatic addrPhase(input logic [3:0] cmd, input logic hit, output logic claimed);
    logic rd, wr;
    rd = (cmd == 4'b0110) || (cmd == 4'b1100) || (cmd == 4'b1110);
    wr = (cmd == 4'b0111) || (cmd == 4'b1111);
    frameN = 1'b0; cbeN = cmd; irdyN = 1'b1; addrHit = 1'b0;
    step();
    check("R2 cmdRead", cmdRead, int'(rd));
    check("R2 cmdWrite", cmdWrite, int'(wr));
    check("R3 no select during compare", devselN, 1);
    cbeN = 4'h0; addrHit = hit;
    step();
    addrHit = 1'b0;
    claimed = hit && (rd || wr);
    check("R3 devselN on claim", devselN, claimed ? 0 : 1);
    check("R3 ctrlOe on claim", ctrlOe, claimed ? 1 : 0);
    if (claimed) begin
      check("R2 cmdRead held", cmdRead, int'(rd));
      check(rd ? "R5 first trdyN" : "R4 first trdyN", trdyN, rd ? 1 : 0);
    end
  endtask

  task automatic runTxn(input logic [3:0] cmd, input logic hit, input int n, input int w);
    logic claimed, rd, xfer, wasHigh;
    int rem, waitLeft, cyc, phase;
    rd = (cmd == 4'b0110) || (cmd == 4'b1100) || (cmd == 4'b1110);
    addrPhase(cmd, hit, claimed);
    if (!claimed) begin
      frameN = 1'b1; irdyN = 1'b0;
      step();
      checkIdle("R3 unclaimed");
      irdyN = 1'b1;
      return;
    end
    rem = n; waitLeft = w; cyc = 0;
    while (rem > 0 && cyc < 50) begin
      if (waitLeft > 0) begin irdyN = 1'b1; waitLeft--; end
      else irdyN = 1'b0;
      frameN = (rem == 1 && irdyN == 1'b0);
      xfer    = (trdyN == 1'b0) && (irdyN == 1'b0);
      wasHigh = trdyN;
      step();
      cyc++;
      if (xfer) begin
        rem--; waitLeft = w;
        if (rem == 0) begin
          check("R7 end trdyN", trdyN, 1);
          check("R7 end devselN", devselN, 1);
          check("R7 end stopN", stopN, 1);
          check("R7 end ctrlOe held", ctrlOe, 1);
        end else
          check(rd ? "R5 wait after word" : "R4 trdy stays low", trdyN, rd ? 1 : 0);
      end else if (!wasHigh)
        check("R6 trdy held during initiator wait", trdyN, 0);
      else
        check("R5 trdy after wait state", trdyN, 0);
    end
    phase = rd ? ((w + 1 > 2) ? w + 1 : 2) : w + 1;
    check(rd ? "R5 burst clocks" : "R4 burst clocks", cyc, n * phase);
    frameN = 1'b1; irdyN = 1'b1;
    step();
    checkIdle("R7 released");
  endtask

  task automatic discTxn(input logic [3:0] cmd);
    logic claimed;
    addrPhase(cmd, 1'b1, claimed);
    discReq = 1'b1; irdyN = 1'b1; frameN = 1'b0;
    step();
    check("R8 stop asserted", stopN, 0);
    check("R8 trdy released", trdyN, 1);
    check("R8 devsel kept", devselN, 0);
    discReq = 1'b0;
    step();
    check("R8 stop held", stopN, 0);
    check("R10 trdy high with stop", trdyN, 1);
    irdyN = 1'b0;
    step();
    check("R9 backoff stopN", stopN, 0);
    check("R9 backoff devselN", devselN, 0);
    check("R9 backoff trdyN", trdyN, 1);
    step();
    check("R9 backoff waits stopN", stopN, 0);
    check("R9 backoff waits devselN", devselN, 0);
    frameN = 1'b1;
    step();
    check("R9 exit trdyN", trdyN, 1);
    check("R9 exit devselN", devselN, 1);
    check("R9 exit stopN", stopN, 1);
    check("R9 exit ctrlOe", ctrlOe, 1);
    irdyN = 1'b1;
    step();
    checkIdle("R9 released");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    rstN = 1'b0; frameN = 1'b1; irdyN = 1'b1; addrHit = 1'b0; discReq = 1'b0; cbeN = 4'hF;
    repeat (3) @(negedge clk);
    checkIdle("R1 in reset");
    rstN = 1'b1;
    step();
    checkIdle("R1 after reset");

    // R11: idle noise without the framing signal
    for (int i = 0; i < 6; i++) begin
      irdyN = i[0]; cbeN = 4'(i + 6); addrHit = ~i[0];
      step();
      checkIdle("R11 idle noise");
    end
    irdyN = 1'b1; addrHit = 1'b0;

    for (int c = 0; c < 16; c++) begin
      for (int h = 0; h < 2; h++) begin
        logic [3:0] code;
        code = 4'(c);
        if (h == 1 && (code == 4'b0110 || code == 4'b1100 || code == 4'b1110 ||
                       code == 4'b0111 || code == 4'b1111)) begin
          for (int n = 1; n <= 3; n++)
            for (int w = 0; w <= 2; w++)
              runTxn(code, 1'b1, n, w);
        end else
          runTxn(code, h[0], 1, 0);
      end
    end

    discTxn(4'b0110);
    discTxn(4'b0111);

    report();
    $finish;
  end

endmodule